// File: doc/BRIEF.md
# Calibrated RTC seconds counter

The block is the timekeeping core of a real-time clock. A strobe from the crystal domain, already brought into the core clock domain, advances a sub-second tick counter. Each time that counter reaches a programmable terminal count, the block produces one seconds event. Each event advances a 32-bit seconds register. A fractional correction can lengthen selected seconds by one tick, which trims the long-term rate of a crystal running near 33.33 kHz.

Software works through a small single-cycle register bus with 32-bit data and a word address. A new time written to the staging register does not replace the running time straight away. It waits for the next seconds event and is loaded at that event. A write to the calibration register restarts the sub-second count, so the first event after the write comes one full calibrated second later. Every seconds event sets a sticky status flag, which software clears by writing a one to it. A control register holds a single read/write bit that enables the battery switch.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset the current time, the staged time, status and control all read 0, and the calibration register reads the CAL_RST parameter.
- R2: The tick counter advances only on cycles where xtal_en_i is high. A seconds event (sec_evt_o high for one cycle, always together with xtal_en_i) occurs on the strobe that brings the strobe count since the last event or calibration write to TC+1, where TC is calibration bits [15:0].
- R3: When calibration bit 20 is set, seconds 0 to F-1 of each 16-second window take TC+2 strobes, where F is calibration bits [19:16]. The remaining seconds take TC+1 strobes. When bit 20 is clear, every second takes TC+1 strobes.
- R4: A write to calibration (word 2, byte offset 0x08) clears the tick count and restarts the 16-second window. No event occurs in the cycle of the write, and the next event comes exactly one calibrated period of strobes later.
- R5: A write to the staging register (word 0, offset 0x00) stores the value and marks it pending. The value reads back at word 1 (offset 0x04). Current time (word 4, offset 0x10) stays unchanged until the next seconds event.
- R6: At a seconds event with a time pending, current time takes the staged value and the pending mark clears.
- R7: At a seconds event with no time pending, current time increments by one, wrapping from 0xFFFFFFFF to 0.
- R8: Status bit 0 (word 8, offset 0x20) sets on every seconds event and stays set. A write with bit 0 high clears it, and an event in the same cycle wins. A write with bit 0 low leaves it set.
- R9: Control (word 16, offset 0x40) bit 31 is read/write. Its other bits read 0.
- R10: Reads of unmapped words return 0. Writes to words 1 and 4 change neither the current time, the staged time nor the pending state.
- R11: Calibration reads back as the 21 low bits of the last write, with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xtal_en_i | input | 1 | One-cycle crystal tick strobe |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| sec_evt_o | output | 1 | Seconds event pulse |

## Verification
The assertions assume that xtal_en_i and the bus inputs are synchronous to clk_i and change only away from its rising edge. They also assume that a calibration write never leaves the tick count above the new terminal count, which holds because every such write clears the count. The bench drives all inputs on the falling edge and holds xtal_en_i low during register accesses, unless a test needs a strobe there. It runs a small reset calibration and sweeps terminal counts from 1 to 5 through every fractional setting, with correction both on and off, in both dense and sparse strobe patterns. The expected strobe counts are computed from the window position.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned OFS_SET_WR = 0;
  localparam int unsigned OFS_SET_RD = 1;
  localparam int unsigned OFS_CAL    = 2;
  localparam int unsigned OFS_CUR    = 4;
  localparam int unsigned OFS_STS    = 8;
  localparam int unsigned OFS_CTRL   = 16;
  localparam int unsigned BATT_BIT   = 31;
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int unsigned TC_W   = 16,
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned CAL_W = TC_W + FRAC_W + 1,
  localparam int unsigned CNT_W = TC_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xtal_en_i,
  input  logic             cal_we_i,
  input  logic [CAL_W-1:0] cal_i,
  output logic             sec_evt_o,
  output logic [CNT_W-1:0] tick_cnt_o
);
  logic [CNT_W-1:0]  cnt_q, limit;
  logic [FRAC_W-1:0] win_q;
  logic              extra;

  generate
    if (FRAC_W > 0) begin : g_frac
      // first F seconds of each 2^FRAC_W window are one tick longer
      assign extra = cal_i[CAL_W-1] && (win_q < cal_i[CAL_W-2 -: FRAC_W]);
    end else begin : g_nofrac
      assign extra = 1'b0;
    end
  endgenerate

  assign limit      = {1'b0, cal_i[TC_W-1:0]} + CNT_W'(extra);
  assign sec_evt_o  = xtal_en_i && !cal_we_i && (cnt_q == limit);
  assign tick_cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      win_q <= '0;
    end else if (cal_we_i) begin
      cnt_q <= '0;
      win_q <= '0;
    end else if (sec_evt_o) begin
      cnt_q <= '0;
      win_q <= win_q + 1'b1;
    end else if (xtal_en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_time_ctr.sv
module rtc_time_ctr #(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_evt_i,
  input  logic              set_we_i,
  input  logic [TIME_W-1:0] set_val_i,
  output logic [TIME_W-1:0] set_q_o,
  output logic              pend_o,
  output logic [TIME_W-1:0] cur_o
);
  logic [TIME_W-1:0] set_q, cur_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q  <= '0;
      cur_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (sec_evt_i) begin
        cur_q  <= pend_q ? set_q : cur_q + 1'b1;
        pend_q <= 1'b0;
      end
      // a new staged value supersedes the transfer flag of this cycle
      if (set_we_i) begin
        set_q  <= set_val_i;
        pend_q <= 1'b1;
      end
    end
  end

  assign set_q_o = set_q;
  assign pend_o  = pend_q;
  assign cur_o   = cur_q;
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned TC_W   = 16,
  parameter int unsigned FRAC_W = 4,
  parameter logic [TC_W+FRAC_W:0] CAL_RST = 21'h198233
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xtal_en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sec_evt_o
);
  import rtc_pkg::*;
  localparam int unsigned CAL_W = TC_W + FRAC_W + 1;
  localparam int unsigned CNT_W = TC_W + 1;

  logic [CAL_W-1:0] cal_q;
  logic             sts_q, batt_q;
  logic             cal_we, set_we, sts_we, ctrl_we;
  logic             sec_evt, pend;
  logic [CNT_W-1:0] tick_cnt;
  logic [31:0]      set_q, cur;

  assign cal_we  = we_i && (addr_i == ADDR_W'(OFS_CAL));
  assign set_we  = we_i && (addr_i == ADDR_W'(OFS_SET_WR));
  assign sts_we  = we_i && (addr_i == ADDR_W'(OFS_STS));
  assign ctrl_we = we_i && (addr_i == ADDR_W'(OFS_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q  <= CAL_RST;
      sts_q  <= 1'b0;
      batt_q <= 1'b0;
    end else begin
      if (cal_we)  cal_q  <= wdata_i[CAL_W-1:0];
      if (ctrl_we) batt_q <= wdata_i[BATT_BIT];
      if (sec_evt)               sts_q <= 1'b1;
      else if (sts_we && wdata_i[0]) sts_q <= 1'b0;
    end
  end

  rtc_tick_gen #(.TC_W(TC_W), .FRAC_W(FRAC_W)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .xtal_en_i (xtal_en_i),
    .cal_we_i  (cal_we),
    .cal_i     (cal_q),
    .sec_evt_o (sec_evt),
    .tick_cnt_o(tick_cnt)
  );

  rtc_time_ctr #(.TIME_W(32)) u_time (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sec_evt_i(sec_evt),
    .set_we_i (set_we),
    .set_val_i(wdata_i),
    .set_q_o  (set_q),
    .pend_o   (pend),
    .cur_o    (cur)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_SET_RD): rdata_o = set_q;
      ADDR_W'(OFS_CAL):    rdata_o = 32'(cal_q);
      ADDR_W'(OFS_CUR):    rdata_o = cur;
      ADDR_W'(OFS_STS):    rdata_o = {31'b0, sts_q};
      ADDR_W'(OFS_CTRL):   rdata_o = {batt_q, 31'b0};
      default:             rdata_o = '0;
    endcase
  end

  assign sec_evt_o = sec_evt;
endmodule

// File: rtl/rtc_sec_core_chk.sv
module rtc_sec_core_chk #(
  parameter int unsigned CNT_W = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             xtal_en_i,
  input logic             cal_we,
  input logic             sec_evt,
  input logic [CNT_W-1:0] tick_cnt,
  input logic             pend,
  input logic [31:0]      set_q,
  input logic [31:0]      cur,
  input logic             sts_q
);
  p_evt_on_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_evt |-> xtal_en_i);
  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xtal_en_i && !cal_we) |=> $stable(tick_cnt));
  p_cal_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_we |=> (tick_cnt == '0));
  p_cal_no_evt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_we |-> !sec_evt);
  p_cur_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_evt |=> $stable(cur));
  p_load_staged_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_evt && pend) |=> (cur == $past(set_q)));
  p_increment_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_evt && !pend) |=> (cur == $past(cur) + 32'd1));
  p_sts_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_evt |=> sts_q);
endmodule

bind rtc_sec_core rtc_sec_core_chk #(.CNT_W(TC_W + 1)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .xtal_en_i(xtal_en_i),
  .cal_we   (cal_we),
  .sec_evt  (sec_evt),
  .tick_cnt (tick_cnt),
  .pend     (pend),
  .set_q    (set_q),
  .cur      (cur),
  .sts_q    (sts_q)
);

// File: tb/rtc_sec_core_bench.sv
module rtc_sec_core_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned ADDR_W = 5;
  localparam logic [20:0] CAL_INIT = 21'h000004;

  logic        clk_i = 1'b0, rst_ni = 1'b0, xtal_en_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        sec_evt_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  rtc_sec_core #(.ADDR_W(ADDR_W), .CAL_RST(CAL_INIT)) u_rtc_sec_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .xtal_en_i(xtal_en_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .sec_evt_o(sec_evt_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    xtal_en_i = 1'b0; we_i = 1'b1; addr_i = ADDR_W'(a); wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    @(negedge clk_i);
    xtal_en_i = 1'b0; we_i = 1'b0; addr_i = ADDR_W'(a);
    #1 d = rdata_o;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    bus_rd(a, d);
    chk(d === exp, req, d, exp);
  endtask

  // strobes until the event strobe, inclusive; sparse inserts an idle cycle before each
  task automatic period(input bit sparse, output int n);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      if (sparse) begin
        @(negedge clk_i); xtal_en_i = 1'b0; we_i = 1'b0;
        #1 if (sec_evt_o) chk(1'b0, "R2 event without strobe", 32'd1, 32'd0);
      end
      @(negedge clk_i); xtal_en_i = 1'b1; we_i = 1'b0;
      #1 n++;
      if (sec_evt_o) break;
    end
  endtask

  task automatic strobes(input int cnt);
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk_i); xtal_en_i = 1'b1; we_i = 1'b0;
      #1 if (sec_evt_o) chk(1'b0, "R4 early event", 32'd1, 32'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n, exp;
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd_chk(1, 32'd0, "R1 staged");
    rd_chk(2, 32'(CAL_INIT), "R1 calib");
    rd_chk(4, 32'd0, "R1 current");
    rd_chk(8, 32'd0, "R1 status");
    rd_chk(16, 32'd0, "R1 control");
    period(1'b0, n);
    chk(n == 5, "R2 reset period", n, 5);

    // R11 calib mask
    bus_wr(2, 32'hFFFF_FFFF);
    rd_chk(2, 32'h001F_FFFF, "R11 calib mask");

    // R2 R3 sweep over terminal counts, fraction settings, strobe density
    for (int sp = 0; sp < 2; sp++)
      for (int tc = 1; tc <= 5; tc++)
        for (int fe = 0; fe < 2; fe++)
          for (int f = 0; f < 16; f++) begin
            bus_wr(2, 32'((fe << 20) | (f << 16) | tc));
            for (int s = 0; s < 18; s++) begin
              period(sp[0], n);
              exp = tc + 1 + ((fe == 1 && (s % 16) < f) ? 1 : 0);
              chk(n == exp, fe ? "R3 fractional period" : "R2 plain period", n, exp);
            end
          end

    // R4 mid-second restart
    bus_wr(2, 32'((1 << 20) | (2 << 16) | 4));
    period(1'b0, n);
    period(1'b0, n);
    period(1'b0, n);
    chk(n == 5, "R3 third second plain", n, 5);
    strobes(3);
    bus_wr(2, 32'((1 << 20) | (2 << 16) | 4));
    period(1'b0, n);
    chk(n == 6, "R4 restart period", n, 6);
    period(1'b0, n);
    chk(n == 6, "R4 window restarted", n, 6);
    // strobe in the cycle of the write is absorbed
    strobes(2);
    @(negedge clk_i);
    xtal_en_i = 1'b1; we_i = 1'b1; addr_i = ADDR_W'(2); wdata_i = 32'd3;
    #1 chk(sec_evt_o == 1'b0, "R4 no event at write", 32'(sec_evt_o), 32'd0);
    period(1'b0, n);
    chk(n == 4, "R4 period after strobed write", n, 4);

    // R8 status
    rd_chk(8, 32'd1, "R8 status set");
    bus_wr(8, 32'hFFFF_FFFE);
    rd_chk(8, 32'd1, "R8 write zero keeps");
    bus_wr(8, 32'd1);
    rd_chk(8, 32'd0, "R8 write one clears");
    strobes(3);
    @(negedge clk_i);
    xtal_en_i = 1'b1; we_i = 1'b1; addr_i = ADDR_W'(8); wdata_i = 32'd1;
    #1 chk(sec_evt_o == 1'b1, "R8 event aligned", 32'(sec_evt_o), 32'd1);
    rd_chk(8, 32'd1, "R8 event beats clear");

    // R5 R6 R7 time load
    bus_rd(4, d);
    bus_wr(0, 32'd100);
    rd_chk(1, 32'd100, "R5 staged readback");
    rd_chk(4, d, "R5 current unchanged");
    strobes(2);
    rd_chk(4, d, "R5 current unchanged mid-second");
    period(1'b0, n);
    rd_chk(4, 32'd100, "R6 loaded");
    period(1'b0, n);
    rd_chk(4, 32'd101, "R7 increment");
    bus_wr(0, 32'hFFFF_FFFF);
    period(1'b0, n);
    rd_chk(4, 32'hFFFF_FFFF, "R6 loaded max");
    period(1'b0, n);
    rd_chk(4, 32'd0, "R7 wrap");

    // R10 ignored writes and unmapped reads
    bus_wr(4, 32'd55);
    rd_chk(4, 32'd0, "R10 current write ignored");
    bus_wr(1, 32'd77);
    rd_chk(1, 32'hFFFF_FFFF, "R10 readback write ignored");
    period(1'b0, n);
    rd_chk(4, 32'd1, "R10 no pending from ignored writes");
    rd_chk(3, 32'd0, "R10 unmapped 3");
    rd_chk(31, 32'd0, "R10 unmapped 31");

    // R9 control
    bus_wr(16, 32'hFFFF_FFFF);
    rd_chk(16, 32'h8000_0000, "R9 battery set");
    bus_wr(16, 32'h7FFF_FFFF);
    rd_chk(16, 32'd0, "R9 battery clear");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule